// File: doc/BRIEF.md
# Masked Packed Float Widening Unit

This block executes one packed widening conversion per request. Up to eight IEEE-754 single-precision lanes are turned into double-precision lanes. The request arrives as a one-cycle `go` pulse together with these inputs:

- the already-loaded source vector;
- the previous destination contents;
- a per-lane write mask;
- control bits for zero-masking, scalar broadcast, memory-sourced operand, vector length and the legacy encoding form;
- a 5-bit register-specifier field.

On the next rising edge the unit presents the new destination vector and a one-cycle valid pulse, and it updates its sticky exception flags.

The widening is exact for every finite input. Single-precision subnormals are normalized into double-precision normals. NaNs keep their payload, and signaling NaNs are quieted and raise the invalid flag. Masking, broadcast and upper-lane clearing wrap the converters. Whether upper lanes are cleared or kept depends on whether the legacy form is selected. A register-specifier field that is not all ones marks the request as an undefined opcode, and in that case nothing is written.

Top module: `fpwiden_unit`

## Requirements
- R1: `vlen` picks the active lane count: code 0 gives 2 lanes, code 1 gives 4, codes 2 and 3 give 8. Result lane n occupies `res_dst[64n+63:64n]` and is converted from source lane n at `src_vec[32n+31:32n]`.
- R2: When `legacy`=0, every destination bit above the active lanes is zero.
- R3: When `legacy`=1, lanes 0 and 1 receive the conversion of their own source lanes whatever `wmask`, `zmask`, `bcast` and `mem_src` are. Bits 511:128 keep the value of `old_dst`.
- R4: When `legacy`=0, an active lane with its `wmask` bit set receives the converted value. An active lane with its `wmask` bit clear becomes zero when `zmask`=1 and keeps its `old_dst` lane when `zmask`=0.
- R5: When `bcast`=1, `mem_src`=1 and `legacy`=0, every written lane receives the conversion of source lane 0. When `mem_src`=0, `bcast` has no effect.
- R6: If `spec` is not 5'b11111, the result has `ud`=1 and `res_dst` equals `old_dst`, and the flags are left unchanged. Otherwise `ud`=0.
- R7: Normal inputs, signed zeros and infinities convert exactly. The sign is kept, the exponent is rebiased by +896 (all ones stays all ones), and the fraction is placed in the top of the 52-bit field with 29 zero bits below.
- R8: A subnormal input with a non-zero fraction becomes a double normal. The exponent is 896 minus the number of leading zeros of the 23-bit fraction. The fraction is the input fraction shifted left past its leading one.
- R9: A NaN input (exponent all ones, non-zero fraction) keeps its sign and payload and gets double fraction bit 51 set. If input fraction bit 22 was clear (signaling), `flg_inv` is set. A quiet NaN sets no flag.
- R10: `flg_inv` is accumulated only from lanes that receive a converted value, stays set until reset, and is never set by masked-off, inactive or undefined-opcode lanes. `flg_inx` is never set, because widening is always exact.
- R11: Outputs are registered. The result appears after the edge that samples `go`, and `res_vld` is high for exactly that one cycle. `res_dst` holds between requests. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| go | input | 1 | request strobe, one cycle per operation |
| src_vec | input | 256 | eight single-precision source lanes |
| old_dst | input | 512 | previous destination contents |
| wmask | input | 8 | per-lane write mask |
| zmask | input | 1 | 1 = zero masked lanes, 0 = keep old |
| bcast | input | 1 | broadcast source lane 0 |
| mem_src | input | 1 | operand came from memory |
| vlen | input | 2 | vector length code |
| legacy | input | 1 | legacy encoding form |
| spec | input | 5 | register-specifier field, must be all ones |
| res_dst | output | 512 | new destination vector |
| res_vld | output | 1 | result valid pulse |
| ud | output | 1 | undefined opcode for the last request |
| flg_inv | output | 1 | sticky invalid-operation flag |
| flg_inx | output | 1 | sticky inexact flag |

## Verification
The assertions take for granted that `go`, the control bits and the vectors are stable across the sampling edge. They also assume that `rst` is held long enough for the first `go` to come after reset. The bench therefore changes every input on the falling edge and raises `go` for a single cycle per request. It never overlaps a request with reset. Each table vector is preceded by a fresh reset, so the sticky invalid flag can be compared per vector.

// File: rtl/fwu_pkg.sv
package fwu_pkg;
  localparam int SP_W    = 32;
  localparam int DP_W    = 64;
  localparam int SP_FRAC = 23;
  localparam int DP_FRAC = 52;
  localparam int PAD_W   = DP_FRAC - SP_FRAC;
  localparam int LZ_W    = $clog2(SP_FRAC + 1);
  localparam logic [10:0] REBIAS = 11'd896;

  typedef logic [SP_W-1:0] sp_t;
  typedef logic [DP_W-1:0] dp_t;
endpackage

// File: rtl/fwu_lzc.sv
module fwu_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic found;
  always_comb begin
    cnt   = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwu_cvt.sv
module fwu_cvt
  import fwu_pkg::*;
(
  input  sp_t  din,
  output dp_t  dout,
  output logic snan
);
  logic               sgn;
  logic [7:0]         ex;
  logic [SP_FRAC-1:0] fr;
  logic [LZ_W-1:0]    lz;
  logic [LZ_W-1:0]    shamt;
  logic [SP_FRAC-1:0] nfr;

  assign sgn   = din[31];
  assign ex    = din[30:23];
  assign fr    = din[22:0];
  assign shamt = lz + LZ_W'(1);
  assign nfr   = fr << shamt;

  fwu_lzc #(.W(SP_FRAC), .CW(LZ_W)) u_lzc (.vec(fr), .cnt(lz));

  always_comb begin
    snan = 1'b0;
    dout = {sgn, 63'd0};
    if (ex == 8'hFF) begin
      if (fr == '0) begin
        dout = {sgn, 11'h7FF, 52'd0};
      end else begin
        dout = {sgn, 11'h7FF, 1'b1, fr[21:0], {PAD_W{1'b0}}};
        snan = ~fr[22];
      end
    end else if (ex == 8'h00) begin
      if (fr != '0)
        dout = {sgn, REBIAS - 11'(lz), nfr, {PAD_W{1'b0}}};
    end else begin
      dout = {sgn, {3'b000, ex} + REBIAS, fr, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fwu_lane.sv
module fwu_lane
  import fwu_pkg::*;
#(
  parameter int IDX = 0
) (
  input  dp_t  conv,
  input  dp_t  old,
  input  logic active,
  input  logic legacy,
  input  logic mbit,
  input  logic zmask,
  output dp_t  lane_out,
  output logic wr
);
  localparam bit LEG_LANE = (IDX < 2);

  always_comb begin
    wr       = 1'b0;
    lane_out = old;
    if (legacy) begin
      if (LEG_LANE) begin
        lane_out = conv;
        wr       = 1'b1;
      end
    end else if (!active) begin
      lane_out = '0;
    end else if (mbit) begin
      lane_out = conv;
      wr       = 1'b1;
    end else if (zmask) begin
      lane_out = '0;
    end
  end
endmodule

// File: rtl/fpwiden_unit.sv
module fpwiden_unit
  import fwu_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int VL_W   = 2,
  parameter int SPEC_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [LANES*32-1:0]   src_vec,
  input  logic [LANES*64-1:0]   old_dst,
  input  logic [LANES-1:0]      wmask,
  input  logic                  zmask,
  input  logic                  bcast,
  input  logic                  mem_src,
  input  logic [VL_W-1:0]       vlen,
  input  logic                  legacy,
  input  logic [SPEC_W-1:0]     spec,
  output logic [LANES*64-1:0]   res_dst,
  output logic                  res_vld,
  output logic                  ud,
  output logic                  flg_inv,
  output logic                  flg_inx
);
  localparam int DST_W = LANES * DP_W;

  logic              bad_op;
  logic              bsel;
  logic [31:0]       act_cnt;
  logic [DST_W-1:0]  nxt;
  logic [LANES-1:0]  wr_v;
  logic [LANES-1:0]  snan_v;
  logic              inv_any;

  assign bad_op  = (spec != {SPEC_W{1'b1}});
  assign bsel    = bcast & mem_src & ~legacy;
  assign act_cnt = 32'd2 << vlen;
  assign inv_any = |(wr_v & snan_v);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    sp_t  sel;
    dp_t  cv;
    logic act;
    assign sel = bsel ? src_vec[31:0] : src_vec[n*SP_W +: SP_W];
    assign act = (32'(n) < act_cnt);

    fwu_cvt u_cvt (.din(sel), .dout(cv), .snan(snan_v[n]));

    fwu_lane #(.IDX(n)) u_lane (
      .conv(cv), .old(old_dst[n*DP_W +: DP_W]), .active(act),
      .legacy(legacy), .mbit(wmask[n]), .zmask(zmask),
      .lane_out(nxt[n*DP_W +: DP_W]), .wr(wr_v[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_dst <= '0;
      res_vld <= 1'b0;
      ud      <= 1'b0;
      flg_inv <= 1'b0;
      flg_inx <= 1'b0;
    end else begin
      res_vld <= go;
      if (go) begin
        ud <= bad_op;
        if (bad_op) begin
          res_dst <= old_dst;
        end else begin
          res_dst <= nxt;
          flg_inv <= flg_inv | inv_any;
        end
      end
    end
  end
endmodule

// File: rtl/fwu_chk.sv
module fwu_chk #(
  parameter int LANES  = 8,
  parameter int SPEC_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                go,
  input logic [LANES*64-1:0] old_dst,
  input logic [LANES-1:0]    wmask,
  input logic                zmask,
  input logic [1:0]          vlen,
  input logic                legacy,
  input logic [SPEC_W-1:0]   spec,
  input logic [LANES*64-1:0] res_dst,
  input logic                res_vld,
  input logic                ud,
  input logic                flg_inv,
  input logic                flg_inx
);
  localparam int DST_W = LANES * 64;
  logic ok;
  assign ok = (spec == {SPEC_W{1'b1}});

  AST_UD_KEEPS_DST: assert property (@(posedge clk) disable iff (rst)
    go && !ok |=> ud && (res_dst == $past(old_dst)));  // R6
  AST_UD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    go && ok |=> !ud);  // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    go && ok && !legacy && vlen == 2'd0 |=> res_dst[DST_W-1:128] == '0);  // R2
  AST_LEGACY_KEEP: assert property (@(posedge clk) disable iff (rst)
    go && ok && legacy |=> res_dst[DST_W-1:128] == $past(old_dst[DST_W-1:128]));  // R3
  AST_ZMASK_LANE0: assert property (@(posedge clk) disable iff (rst)
    go && ok && !legacy && zmask && !wmask[0] |=> res_dst[63:0] == '0);  // R4
  AST_INV_STICKY: assert property (@(posedge clk) disable iff (rst)
    flg_inv |=> flg_inv);  // R10
  AST_INX_NEVER: assert property (@(posedge clk) disable iff (rst)
    !flg_inx);  // R10
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    go |=> res_vld);  // R11
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !go |=> !res_vld);  // R11
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(res_dst));  // R11
endmodule

bind fpwiden_unit fwu_chk #(.LANES(LANES), .SPEC_W(SPEC_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .old_dst(old_dst), .wmask(wmask),
  .zmask(zmask), .vlen(vlen), .legacy(legacy), .spec(spec),
  .res_dst(res_dst), .res_vld(res_vld), .ud(ud),
  .flg_inv(flg_inv), .flg_inx(flg_inx)
);

// File: tb/sim_fpwiden_unit.sv
module sim_fpwiden_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {input single, expected double, expected invalid}
  localparam logic [96:0] TBL [NV] = '{
    {32'h3F800000, 64'h3FF0000000000000, 1'b0},  // 1.0
    {32'hC0490FDB, 64'hC00921FB60000000, 1'b0},  // -pi
    {32'h00000000, 64'h0000000000000000, 1'b0},  // +0
    {32'h80000000, 64'h8000000000000000, 1'b0},  // -0
    {32'h7F800000, 64'h7FF0000000000000, 1'b0},  // +inf
    {32'hFF800000, 64'hFFF0000000000000, 1'b0},  // -inf
    {32'h7FC00000, 64'h7FF8000000000000, 1'b0},  // qNaN
    {32'h7F800001, 64'h7FF8000020000000, 1'b1},  // sNaN
    {32'hFFA00000, 64'hFFFC000000000000, 1'b1},  // -sNaN
    {32'h00000001, 64'h36A0000000000000, 1'b0},  // min subnormal
    {32'h00400000, 64'h3800000000000000, 1'b0},  // 2^-127
    {32'h007FFFFF, 64'h380FFFFFC0000000, 1'b0},  // max subnormal
    {32'h00000003, 64'h36B8000000000000, 1'b0},  // 3 * 2^-149
    {32'h7F7FFFFF, 64'h47EFFFFFE0000000, 1'b0},  // max normal
    {32'h00800000, 64'h3810000000000000, 1'b0}   // min normal
  };
  localparam int PICK [8] = '{0, 1, 4, 6, 9, 11, 12, 14};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go = 1'b0;
  logic [255:0] src_vec = '0;
  logic [511:0] old_dst = '0;
  logic [7:0]   wmask = '0;
  logic         zmask = 1'b0, bcast = 1'b0, mem_src = 1'b0, legacy = 1'b0;
  logic [1:0]   vlen = '0;
  logic [4:0]   spec = 5'h1F;
  logic [511:0] res_dst;
  logic         res_vld, ud, flg_inv, flg_inx;

  logic [31:0] src_l [8];
  logic [63:0] cvt_l [8];
  logic [63:0] old_l [8];
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpwiden_unit u0 (
    .clk(clk), .rst(rst), .go(go), .src_vec(src_vec), .old_dst(old_dst),
    .wmask(wmask), .zmask(zmask), .bcast(bcast), .mem_src(mem_src),
    .vlen(vlen), .legacy(legacy), .spec(spec), .res_dst(res_dst),
    .res_vld(res_vld), .ud(ud), .flg_inv(flg_inv), .flg_inx(flg_inx)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic pack_inputs();
    for (int n = 0; n < 8; n++) begin
      src_vec[n*32 +: 32] = src_l[n];
      old_dst[n*64 +: 64] = old_l[n];
    end
  endtask

  // drives one request at a falling edge; returns at the next falling edge
  task automatic run_op(input logic [1:0] vl, input logic [7:0] m, input logic z,
                        input logic b, input logic ms, input logic lg, input logic [4:0] sp);
    @(negedge clk);
    pack_inputs();
    vlen = vl; wmask = m; zmask = z; bcast = b; mem_src = ms; legacy = lg; spec = sp;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  function automatic logic [511:0] model(input logic [1:0] vl, input logic [7:0] m,
      input logic z, input logic b, input logic ms, input logic lg);
    logic [511:0] r;
    int act;
    act = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    for (int n = 0; n < 8; n++) begin
      logic [63:0] v;
      int si;
      si = (b && ms && !lg) ? 0 : n;
      if (lg) v = (n < 2) ? cvt_l[n] : old_l[n];
      else if (n >= act) v = '0;
      else if (m[n]) v = cvt_l[si];
      else if (z) v = '0;
      else v = old_l[n];
      r[n*64 +: 64] = v;
    end
    return r;
  endfunction

  task automatic op_chk(input string tag, input logic [1:0] vl, input logic [7:0] m,
      input logic z, input logic b, input logic ms, input logic lg);
    run_op(vl, m, z, b, ms, lg, 5'h1F);
    chk(tag, res_dst, model(vl, m, z, b, ms, lg));
  endtask

  task automatic set_default_lanes();
    for (int n = 0; n < 8; n++) begin
      src_l[n] = TBL[PICK[n]][96:65];
      cvt_l[n] = TBL[PICK[n]][64:1];
      old_l[n] = 64'hDEAD_BEEF_0000_0000 | 64'(n + 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    set_default_lanes();
    do_reset();
    // R11 reset state
    chk("R11 reset dst", res_dst, '0);
    chk("R11 reset flags", {res_vld, ud, flg_inv, flg_inx}, '0);

    // R7 R8 R9 conversion table, all lanes fed the same value
    for (int i = 0; i < NV; i++) begin
      do_reset();
      for (int n = 0; n < 8; n++) begin
        src_l[n] = TBL[i][96:65];
        cvt_l[n] = TBL[i][64:1];
      end
      op_chk($sformatf("R7/R8/R9 vector %0d", i), 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
      chk($sformatf("R9 invalid vector %0d", i), 512'(flg_inv), 512'(TBL[i][0]));
    end

    do_reset();
    set_default_lanes();
    // R1 R2 vector lengths
    op_chk("R1 R2 vlen0", 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 valid pulse", 512'(res_vld), 512'd1);
    @(negedge clk);
    chk("R11 valid drops", 512'(res_vld), 512'd0);
    chk("R11 dst holds", res_dst, model(2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0));
    op_chk("R1 R2 vlen1", 2'd1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    op_chk("R1 vlen2", 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    op_chk("R1 vlen3", 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4 merge and zero masking
    op_chk("R4 merge", 2'd2, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    op_chk("R4 zero", 2'd2, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
    op_chk("R4 R2 zero vlen1", 2'd1, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5 broadcast
    op_chk("R5 broadcast mem", 2'd2, 8'h7E, 1'b0, 1'b1, 1'b1, 1'b0);
    op_chk("R5 broadcast reg ignored", 2'd2, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3 legacy ignores mask, zero-masking, broadcast
    op_chk("R3 legacy", 2'd2, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R10 no invalid yet", 512'(flg_inv), 512'd0);

    // R6 undefined opcode with an sNaN in lane 0
    src_l[0] = 32'h7F800001;
    run_op(2'd2, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 5'h1E);
    chk("R6 ud set", 512'(ud), 512'd1);
    chk("R6 dst unchanged", res_dst, old_dst);
    chk("R6 flag unchanged", 512'(flg_inv), 512'd0);
    set_default_lanes();
    op_chk("R6 ud clears", 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 ud low", 512'(ud), 512'd0);

    // R10 flags only from written lanes
    src_l[3] = 32'h7F800001;
    run_op(2'd2, 8'hF7, 1'b1, 1'b0, 1'b0, 1'b0, 5'h1F);
    chk("R10 masked sNaN", 512'(flg_inv), 512'd0);
    src_l[3] = TBL[PICK[3]][96:65];
    src_l[5] = 32'h7F800001;
    run_op(2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 5'h1F);
    chk("R10 inactive sNaN", 512'(flg_inv), 512'd0);
    src_l[5] = TBL[PICK[5]][96:65];
    src_l[2] = 32'h7F800001;
    run_op(2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 5'h1F);
    chk("R10 legacy upper sNaN", 512'(flg_inv), 512'd0);
    src_l[2] = TBL[PICK[2]][96:65];
    src_l[1] = 32'hFFA00000;
    run_op(2'd0, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 5'h1F);
    chk("R10 written sNaN", 512'(flg_inv), 512'd1);
    set_default_lanes();
    run_op(2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 5'h1F);
    chk("R10 sticky", 512'(flg_inv), 512'd1);
    chk("R10 inexact never", 512'(flg_inx), 512'd0);
    do_reset();
    chk("R10 R11 reset clears flag", 512'(flg_inv), 512'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule